// File: doc/BRIEF.md
# I3C SDR Bus Frame Monitor

This block watches the two wires of a mixed I3C/I2C bus without driving them and turns what it sees into a stream of typed events. The two lines are synchronised into the system clock domain. Their edges are found by comparing successive samples. A per-transaction state machine follows the bus through the address byte, the acknowledge slot, the data bytes and the bit that comes after each byte.

A transaction starts in plain I2C form: an ACK or NACK follows every byte. When the broadcast address 0x7E appears, the monitor switches to SDR mode until the next STOP. In SDR mode a written byte is followed by a parity bit, which is checked. A read byte is followed by a transition bit, which is sampled twice: once as SCL rises and once as it falls. That bit shows whether the read goes on, or whether the target or the controller ended it.

Each event is a single-cycle pulse on `evt_valid` with a 4-bit code, an 8-bit value and an error flag. A controller model or a protocol scoreboard can consume the stream as it comes.

Top module: `sdr_frame_monitor`

## Requirements
- R1: SDA falling while SCL is high gives event code 1 (START) when the monitor is idle. SDA rising while SCL is high gives code 3 (STOP) and returns the monitor to idle. Both carry value 0x00.
- R2: A START condition seen while a transaction is open (after a START and before a STOP) gives code 2 (repeated START) and begins a new address byte.
- R3: Bits are sampled at SCL rising edges and packed most significant bit first. The first byte after a START is reported as code 4 with the whole byte as value: bits [7:1] are the address and bit 0 is the direction, 1 for read. Later bytes are reported as code 5.
- R4: The bit after an address byte, and after any data byte outside SDR mode, gives code 6 (ACK) when SDA is 0 and code 7 (NACK) when SDA is 1. After a NACK, further SCL clocks give no events until STOP or repeated START.
- R5: An address byte whose bits [7:1] equal 0x7E puts the monitor into SDR mode for the rest of the transaction, repeated STARTs included. In SDR mode a data byte is never followed by an ACK/NACK event.
- R6: In SDR mode the bit after a written data byte gives code 8 with the sampled bit in value bit 0. `evt_err` is 1 exactly when the byte and that bit together hold an even number of ones.
- R7: In SDR mode the bit after a read data byte gives code 9. Value bit 1 is SDA at the SCL rising edge and value bit 0 is SDA as SCL falls. The pair 1,1 continues the read. Any other pair ends it, and later SCL clocks give no events until STOP or repeated START.
- R8: A START or STOP condition seen partway through a byte drops the partial byte, with no byte event, and is reported at once.
- R9: `evt_valid` is low after reset and is never high for two cycles in a row. `evt_err` is high only together with a code-8 event.
- R10: STOP clears SDR mode, so the next transaction that does not use 0x7E uses ACK/NACK after its data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_code | output | 4 | Event type (1..9, see requirements) |
| evt_data | output | 8 | Byte value or sampled bit(s) |
| evt_err | output | 1 | Parity error on a write T-bit |

## Verification
The first pattern is a plain I2C write with ACKs, and it is run again right after an SDR transaction. Comparing the two shows that the broadcast-address mode switch is applied and is then cleared by STOP. SDR writes use one byte with odd weight and one with even weight, which separates a correct parity check from an inverted one. SDR reads end their transfer in three ways (continue, target-ended and controller-ended), with extra SCL clocks after the end, which proves that the second sample is taken as SCL falls. NACK-then-clocks and START or STOP dropped into the middle of a byte show that partial bytes and clocks after the end of a transfer make no events.

// File: rtl/sdr_frame_monitor.sv
module sdr_frame_monitor #(
  parameter logic [6:0] BCAST_ADDR = 7'h7E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       evt_valid,
  output logic [3:0] evt_code,
  output logic [7:0] evt_data,
  output logic       evt_err
);

  localparam logic [3:0] C_START  = 4'd1;
  localparam logic [3:0] C_RSTART = 4'd2;
  localparam logic [3:0] C_STOP   = 4'd3;
  localparam logic [3:0] C_ADDR   = 4'd4;
  localparam logic [3:0] C_DATA   = 4'd5;
  localparam logic [3:0] C_ACK    = 4'd6;
  localparam logic [3:0] C_NACK   = 4'd7;
  localparam logic [3:0] C_TWR    = 4'd8;
  localparam logic [3:0] C_TRD    = 4'd9;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACK, S_DATA, S_WPAR, S_RTB_HI, S_RTB_LO, S_WAIT
  } state_t;

  state_t     state;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [7:0] shreg;
  logic [2:0] bitcnt;
  logic       sdr, rnw, tb_hi;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] nxt_byte  = {shreg[6:0], sda_s};
  wire       byte_done = scl_rise && (bitcnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      sdr       <= 1'b0;
      rnw       <= 1'b0;
      tb_hi     <= 1'b0;
      evt_valid <= 1'b0;
      evt_code  <= '0;
      evt_data  <= '0;
      evt_err   <= 1'b0;
    end else begin
      evt_valid <= 1'b0;
      evt_err   <= 1'b0;
      if (start_c) begin
        evt_valid <= 1'b1;
        evt_code  <= (state == S_IDLE) ? C_START : C_RSTART;
        evt_data  <= '0;
        state     <= S_ADDR;
        bitcnt    <= '0;
      end else if (stop_c) begin
        evt_valid <= 1'b1;
        evt_code  <= C_STOP;
        evt_data  <= '0;
        state     <= S_IDLE;
        bitcnt    <= '0;
        sdr       <= 1'b0;
        rnw       <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_DATA: if (scl_rise) begin
            shreg  <= nxt_byte;
            bitcnt <= bitcnt + 3'd1;
            if (byte_done) begin
              evt_valid <= 1'b1;
              evt_data  <= nxt_byte;
              if (state == S_ADDR) begin
                evt_code <= C_ADDR;
                rnw      <= nxt_byte[0];
                if (nxt_byte[7:1] == BCAST_ADDR) sdr <= 1'b1;
                state    <= S_ACK;
              end else begin
                evt_code <= C_DATA;
                if (!sdr)     state <= S_ACK;
                else if (rnw) state <= S_RTB_HI;
                else          state <= S_WPAR;
              end
            end
          end
          S_ACK: if (scl_rise) begin
            evt_valid <= 1'b1;
            evt_code  <= sda_s ? C_NACK : C_ACK;
            evt_data  <= '0;
            state     <= sda_s ? S_WAIT : S_DATA;
          end
          S_WPAR: if (scl_rise) begin
            evt_valid <= 1'b1;
            evt_code  <= C_TWR;
            evt_data  <= {7'd0, sda_s};
            evt_err   <= ~(^shreg ^ sda_s);
            state     <= S_DATA;
          end
          S_RTB_HI: if (scl_rise) begin
            tb_hi <= sda_s;
            state <= S_RTB_LO;
          end
          S_RTB_LO: if (scl_fall) begin
            evt_valid <= 1'b1;
            evt_code  <= C_TRD;
            evt_data  <= {6'd0, tb_hi, sda_s};
            state     <= (tb_hi && sda_s) ? S_DATA : S_WAIT;
          end
          default: ;
        endcase
      end
    end
  end

  AST_START_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> evt_valid && (evt_code == C_START || evt_code == C_RSTART)); // R1
  AST_RSTART_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c && state != S_IDLE) |=> evt_code == C_RSTART); // R2
  AST_STOP_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> evt_valid && evt_code == C_STOP); // R1
  AST_SDR_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (sdr && state == S_DATA && byte_done && !start_c && !stop_c) |=> evt_code == C_DATA && state != S_ACK); // R5
  AST_ERR_ON_TWR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |-> evt_valid && evt_code == C_TWR); // R9
  AST_TRD_IN_SDR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code == C_TRD) |-> sdr); // R7
  AST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid); // R9

endmodule

// File: tb/sdr_frame_monitor_bench.sv
`timescale 1ns/1ps
module sdr_frame_monitor_bench;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic       evt_valid, evt_err;
  logic [3:0] evt_code;
  logic [7:0] evt_data;

  int total = 0;
  int bad = 0;
  int n = 0;
  int run = 0;
  int pulse_bad = 0;
  int err_bad = 0;
  logic [3:0] rc [64];
  logic [7:0] rd [64];
  logic       re [64];

  always #2 clk = ~clk;

  sdr_frame_monitor u_sdr_frame_monitor (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_data(evt_data), .evt_err(evt_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (evt_valid) begin
        if (n < 64) begin
          rc[n] = evt_code; rd[n] = evt_data; re[n] = evt_err;
        end
        n = n + 1;
        run = run + 1;
        if (run > 1) pulse_bad = pulse_bad + 1;
      end else begin
        run = 0;
      end
      if (evt_err && !(evt_valid && evt_code == 4'd8)) err_bad = err_bad + 1;
    end
  end

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    sda = 1'b1; hw(); scl = 1'b1; hw(); sda = 1'b0; hw(); scl = 1'b0; hw();
  endtask

  task automatic bus_stop();
    sda = 1'b0; hw(); scl = 1'b1; hw(); sda = 1'b1; hw(); hw();
  endtask

  task automatic bus_bit(input logic b);
    sda = b; hw(); scl = 1'b1; hw(); scl = 1'b0; hw();
  endtask

  task automatic bus_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
  endtask

  task automatic bus_tbit_rd(input logic a, input logic b);
    sda = a; hw(); scl = 1'b1; hw(); scl = 1'b0; sda = b; hw();
  endtask

  task automatic expect_ev(input int i, input logic [3:0] c, input logic [7:0] d,
                           input logic e, input string tag);
    total++;
    if (i >= n) begin
      bad++;
      $display("FAIL %s: event %0d missing, got %0d events, expected code=%0d data=%02h", tag, i, n, c, d);
    end else if (rc[i] !== c || rd[i] !== d || re[i] !== e) begin
      bad++;
      $display("FAIL %s: event %0d actual code=%0d data=%02h err=%0b expected code=%0d data=%02h err=%0b",
               tag, i, rc[i], rd[i], re[i], c, d, e);
    end
  endtask

  task automatic expect_count(input int c, input string tag);
    total++;
    if (n != c) begin
      bad++;
      $display("FAIL %s: event count actual=%0d expected=%0d", tag, n, c);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic t_reset();
    total++;
    if (evt_valid !== 1'b0 || n != 0) begin
      bad++;
      $display("FAIL R9: after reset evt_valid=%0b events=%0d expected 0 and 0", evt_valid, n);
    end
  endtask

  task automatic t_i2c_write(input string tag);
    n = 0;
    bus_start(); bus_byte(8'hA0); bus_bit(1'b0);
    bus_byte(8'h3C); bus_bit(1'b0); bus_stop();
    expect_count(6, tag);
    expect_ev(0, 4'd1, 8'h00, 1'b0, {tag, " R1 start"});
    expect_ev(1, 4'd4, 8'hA0, 1'b0, {tag, " R3 addr"});
    expect_ev(2, 4'd6, 8'h00, 1'b0, {tag, " R4 ack"});
    expect_ev(3, 4'd5, 8'h3C, 1'b0, {tag, " R3 data"});
    expect_ev(4, 4'd6, 8'h00, 1'b0, {tag, " R4 R10 data ack"});
    expect_ev(5, 4'd3, 8'h00, 1'b0, {tag, " R1 stop"});
  endtask

  task automatic t_nack();
    n = 0;
    bus_start(); bus_byte(8'hA1); bus_bit(1'b1);
    bus_bit(1'b0); bus_bit(1'b1); bus_bit(1'b0); bus_stop();
    expect_count(4, "R4 nack");
    expect_ev(1, 4'd4, 8'hA1, 1'b0, "R3 read addr");
    expect_ev(2, 4'd7, 8'h00, 1'b0, "R4 nack code");
    expect_ev(3, 4'd3, 8'h00, 1'b0, "R4 clocks ignored then stop");
  endtask

  task automatic t_sdr_write();
    n = 0;
    bus_start(); bus_byte(8'hFC); bus_bit(1'b0);
    bus_byte(8'h07); bus_bit(1'b0);
    bus_byte(8'h03); bus_bit(1'b0);
    bus_start(); bus_byte(8'h24); bus_bit(1'b0);
    bus_byte(8'h81); bus_bit(1'b1);
    bus_stop();
    expect_count(13, "R5 sdr write");
    expect_ev(1, 4'd4, 8'hFC, 1'b0, "R5 bcast addr");
    expect_ev(4, 4'd8, 8'h00, 1'b0, "R6 odd parity ok");
    expect_ev(5, 4'd5, 8'h03, 1'b0, "R5 no ack after data");
    expect_ev(6, 4'd8, 8'h00, 1'b1, "R6 parity error");
    expect_ev(7, 4'd2, 8'h00, 1'b0, "R2 repeated start");
    expect_ev(8, 4'd4, 8'h24, 1'b0, "R2 addr after sr");
    expect_ev(11, 4'd8, 8'h01, 1'b0, "R5 sdr kept across sr");
    expect_ev(12, 4'd3, 8'h00, 1'b0, "R1 stop");
  endtask

  task automatic t_sdr_read();
    n = 0;
    bus_start(); bus_byte(8'hFC); bus_bit(1'b0);
    bus_start(); bus_byte(8'h25); bus_bit(1'b0);
    bus_byte(8'h5A); bus_tbit_rd(1'b1, 1'b1);
    bus_byte(8'hA5); bus_tbit_rd(1'b0, 1'b0);
    bus_bit(1'b1); bus_bit(1'b0);
    bus_stop();
    expect_count(11, "R7 read target end");
    expect_ev(6, 4'd5, 8'h5A, 1'b0, "R7 read byte");
    expect_ev(7, 4'd9, 8'h03, 1'b0, "R7 continue");
    expect_ev(8, 4'd5, 8'hA5, 1'b0, "R7 second byte");
    expect_ev(9, 4'd9, 8'h00, 1'b0, "R7 target ended");
    expect_ev(10, 4'd3, 8'h00, 1'b0, "R7 clocks after end ignored");
  endtask

  task automatic t_sdr_read_ctrl_end();
    n = 0;
    bus_start(); bus_byte(8'hFC); bus_bit(1'b0);
    bus_start(); bus_byte(8'h25); bus_bit(1'b0);
    bus_byte(8'h11); bus_tbit_rd(1'b1, 1'b0);
    bus_bit(1'b1);
    bus_stop();
    expect_count(9, "R7 controller end");
    expect_ev(7, 4'd9, 8'h02, 1'b0, "R7 controller ended pair");
    expect_ev(8, 4'd3, 8'h00, 1'b0, "R7 stop after end");
  endtask

  task automatic t_abort();
    n = 0;
    bus_start(); bus_byte(8'hA0); bus_bit(1'b0);
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1); bus_bit(1'b1);
    bus_stop();
    expect_count(4, "R8 stop mid-byte");
    expect_ev(3, 4'd3, 8'h00, 1'b0, "R8 stop drops byte");
    n = 0;
    bus_start(); bus_byte(8'hA0); bus_bit(1'b0);
    bus_bit(1'b1); bus_bit(1'b1); bus_bit(1'b0);
    bus_start(); bus_byte(8'hB2); bus_bit(1'b0);
    bus_stop();
    expect_count(7, "R8 sr mid-byte");
    expect_ev(3, 4'd2, 8'h00, 1'b0, "R8 sr drops byte");
    expect_ev(4, 4'd4, 8'hB2, 1'b0, "R8 fresh addr after sr");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_i2c_write("plain write");
    t_nack();
    t_sdr_write();
    t_i2c_write("R10 after sdr");
    t_sdr_read();
    t_sdr_read_ctrl_end();
    t_abort();
    total++;
    if (pulse_bad != 0) begin
      bad++;
      $display("FAIL R9: multi-cycle valid actual=%0d expected=0", pulse_bad);
    end
    total++;
    if (err_bad != 0) begin
      bad++;
      $display("FAIL R9: stray evt_err actual=%0d expected=0", err_bad);
    end
    summary();
    $finish;
  end
endmodule